// File: doc/BRIEF.md
# Bank-Partitioned Dual-Port Word Memory

This block is a two-port synchronous RAM whose storage is split into four banks of equal size. Each bank belongs to exactly one of the two ports at any moment. The owner is chosen by a static per-bank steering input. The port that owns a bank may read and write it freely. The other port's accesses to that bank change nothing and return a fixed poison word. Both ports can never write the same bank, so no arbitration logic is needed.

Each port has a chip enable, an address, two byte-lane write enables, write data, registered read data and a debug flag. The two most significant address bits select the bank. The rest of the address is the word offset inside that bank. The bank depth is set by a parameter. A 16K-word bank uses `BANK_AW = 14`. The default is kept small.

System software may move a bank from one port to the other while the remaining banks stay in use. If an access lands on a bank whose steering input changes in that same cycle, it counts as not owned. The block then raises the port's debug flag.

Top module: `bo_dpram`

## Requirements
- R1: The bank index is the two most significant address bits. Bank b holds addresses b*2^BANK_AW up to (b+1)*2^BANK_AW-1.
- R2: Steering bit b at 1 gives bank b to the left port. At 0 it gives bank b to the right port.
- R3: In an owned write, be[0] writes data bits 7:0 and be[1] writes bits 15:8. A lane whose enable is 0 keeps its old contents.
- R4: An owned access with ce=1 loads the addressed word into rdata at the next clock edge. If the same access also writes, rdata shows the contents from before the write.
- R5: A write to a bank the port does not own leaves memory unchanged.
- R6: Any ce=1 access to a bank the port does not own loads rdata with the poison word 16'hDEAD.
- R7: With ce=0 a port writes nothing and its rdata holds its previous value.
- R8: Any split of ownership is valid, from zero to all four banks on one port. Both ports work at the same time in different banks.
- R9: Accesses to banks whose steering is unchanged keep working in the cycle where another bank is reassigned.
- R10: An access to a bank whose steering bit differs from its value in the previous cycle counts as not owned. The write is dropped and rdata gets the poison word. The port's clash flag is 1 during the following cycle only.
- R11: A synchronous active-high reset clears both rdata outputs and both clash flags to 0. It does not alter memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| own_sel | input | 4 | Per-bank owner steering, 1 = left port |
| lp_ce | input | 1 | Left port chip enable |
| lp_be | input | 2 | Left port byte-lane write enables |
| lp_addr | input | BANK_AW+2 | Left port word address |
| lp_wdata | input | 16 | Left port write data |
| lp_rdata | output | 16 | Left port registered read data |
| lp_clash | output | 1 | Left port access hit a bank being reassigned |
| rp_ce | input | 1 | Right port chip enable |
| rp_be | input | 2 | Right port byte-lane write enables |
| rp_addr | input | BANK_AW+2 | Right port word address |
| rp_wdata | input | 16 | Right port write data |
| rp_rdata | output | 16 | Right port registered read data |
| rp_clash | output | 1 | Right port access hit a bank being reassigned |

## Verification
Two functions can fall in the same cycle: moving one bank to the other port, and a port access, either to that same bank or to an untouched bank.

The bench changes a steering bit in the same cycle that one port writes the bank being moved, while the other port reads a stable bank. A pass needs three things:
- the write must vanish, which a later owned read confirms;
- the writer must get poison and a one-cycle clash pulse;
- the reader must get its correct word with no clash.

A second case gives every bank to one port while the other port reads a bank that is leaving it.

// File: rtl/bo_pkg.sv
package bo_pkg;

    localparam int DATA_W     = 16;
    localparam int BYTE_W     = 8;
    localparam int LANES      = DATA_W / BYTE_W;
    localparam int NUM_BANKS  = 4;
    localparam int BANK_IDX_W = $clog2(NUM_BANKS);
    localparam logic [DATA_W-1:0] POISON = 16'hDEAD;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [LANES-1:0]  lane_t;
    typedef logic [NUM_BANKS-1:0] bank_vec_t;
    typedef logic [NUM_BANKS-1:0][DATA_W-1:0] bank_words_t;

    // One port's access request for a cycle.
    typedef struct packed {
        logic  ce;
        lane_t be;
        word_t wdata;
    } acc_t;

    // Encoding of a steering bit.
    typedef enum logic {
        OWNER_RIGHT = 1'b0,
        OWNER_LEFT  = 1'b1
    } owner_e;

    function automatic word_t merge_lanes(word_t old_w, word_t new_w, lane_t be);
        word_t res;
        res = old_w;
        for (int i = 0; i < LANES; i++) begin
            if (be[i]) res[i*BYTE_W +: BYTE_W] = new_w[i*BYTE_W +: BYTE_W];
        end
        return res;
    endfunction

endpackage

// File: rtl/bo_sel_track.sv
module bo_sel_track
    import bo_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bank_vec_t sel_i,
    output bank_vec_t own_l_o,
    output bank_vec_t own_r_o,
    output bank_vec_t chg_o
);
    bank_vec_t sel_q;

    // Reset captures the live steering, so no false change follows reset.
    always_ff @(posedge clk) begin
        sel_q <= sel_i;
    end

    always_comb begin
        chg_o = rst ? '0 : (sel_i ^ sel_q);
        for (int b = 0; b < NUM_BANKS; b++) begin
            own_l_o[b] = (owner_e'(sel_i[b]) == OWNER_LEFT)  && !chg_o[b];
            own_r_o[b] = (owner_e'(sel_i[b]) == OWNER_RIGHT) && !chg_o[b];
        end
    end
endmodule

// File: rtl/bo_bank.sv
module bo_bank
    import bo_pkg::*;
#(
    parameter int OFF_W = 8,
    localparam int DEPTH = 1 << OFF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  acc_t             l_acc,
    input  logic [OFF_W-1:0] l_off,
    input  logic             l_own,
    input  acc_t             r_acc,
    input  logic [OFF_W-1:0] r_off,
    input  logic             r_own,
    output word_t            l_rd,
    output word_t            r_rd
);
    word_t mem [DEPTH];
    logic  wr_l, wr_r;

    assign wr_l = l_acc.ce && (|l_acc.be) && l_own;
    assign wr_r = r_acc.ce && (|r_acc.be) && r_own;

    always_ff @(posedge clk) begin
        if (wr_l)      mem[l_off] <= merge_lanes(mem[l_off], l_acc.wdata, l_acc.be);
        else if (wr_r) mem[r_off] <= merge_lanes(mem[r_off], r_acc.wdata, r_acc.be);
    end

    assign l_rd = mem[l_off];
    assign r_rd = mem[r_off];

    // The two ports never both write one bank.
    assert_single_writer_R2: assert property (@(posedge clk) disable iff (rst)
        !(wr_l && wr_r))
        else $error("two writers in one bank");
endmodule

// File: rtl/bo_port.sv
module bo_port
    import bo_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_t              acc,
    input  logic [ADDR_W-1:0] addr,
    input  bank_vec_t         own_i,
    input  bank_vec_t         chg_i,
    input  bank_words_t       bank_rd,
    output word_t             rdata_o,
    output logic              race_o
);
    logic [BANK_IDX_W-1:0] idx;
    logic                  hit;

    assign idx = addr[ADDR_W-1 -: BANK_IDX_W];
    assign hit = own_i[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_o <= '0;
            race_o  <= 1'b0;
        end else begin
            race_o <= acc.ce && chg_i[idx];
            if (acc.ce) rdata_o <= hit ? bank_rd[idx] : POISON;
        end
    end

    assert_poison_R6: assert property (@(posedge clk) disable iff (rst)
        (acc.ce && !hit) |=> (rdata_o == POISON))
        else $error("non-owned access did not return poison");

    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !acc.ce |=> $stable(rdata_o))
        else $error("rdata moved while idle");

    assert_clash_flag_R10: assert property (@(posedge clk) disable iff (rst)
        (acc.ce && chg_i[idx]) |=> race_o)
        else $error("clash flag missing");

    assert_clash_needs_access_R10: assert property (@(posedge clk) disable iff (rst)
        !acc.ce |=> !race_o)
        else $error("clash flag without access");
endmodule

// File: rtl/bo_dpram.sv
module bo_dpram
    import bo_pkg::*;
#(
    parameter int BANK_AW = 8,
    localparam int ADDR_W = BANK_AW + BANK_IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        own_sel,
    input  logic              lp_ce,
    input  logic [1:0]        lp_be,
    input  logic [ADDR_W-1:0] lp_addr,
    input  logic [15:0]       lp_wdata,
    output logic [15:0]       lp_rdata,
    output logic              lp_clash,
    input  logic              rp_ce,
    input  logic [1:0]        rp_be,
    input  logic [ADDR_W-1:0] rp_addr,
    input  logic [15:0]       rp_wdata,
    output logic [15:0]       rp_rdata,
    output logic              rp_clash
);
    acc_t        l_acc, r_acc;
    bank_vec_t   own_l, own_r, chg;
    bank_words_t l_rd, r_rd;
    logic [BANK_AW-1:0]    l_off, r_off;
    logic [BANK_IDX_W-1:0] l_idx, r_idx;

    assign l_acc = '{ce: lp_ce, be: lp_be, wdata: lp_wdata};
    assign r_acc = '{ce: rp_ce, be: rp_be, wdata: rp_wdata};
    assign l_off = lp_addr[BANK_AW-1:0];
    assign r_off = rp_addr[BANK_AW-1:0];
    assign l_idx = lp_addr[ADDR_W-1 -: BANK_IDX_W];
    assign r_idx = rp_addr[ADDR_W-1 -: BANK_IDX_W];

    bo_sel_track u_track (
        .clk(clk), .rst(rst), .sel_i(own_sel),
        .own_l_o(own_l), .own_r_o(own_r), .chg_o(chg)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        acc_t l_acc_b, r_acc_b;
        // Each bank only sees a request whose address selects it.
        assign l_acc_b = (l_idx == BANK_IDX_W'(b)) ? l_acc : '0;
        assign r_acc_b = (r_idx == BANK_IDX_W'(b)) ? r_acc : '0;

        bo_bank #(.OFF_W(BANK_AW)) u_bank (
            .clk(clk), .rst(rst),
            .l_acc(l_acc_b), .l_off(l_off), .l_own(own_l[b]),
            .r_acc(r_acc_b), .r_off(r_off), .r_own(own_r[b]),
            .l_rd(l_rd[b]), .r_rd(r_rd[b])
        );
    end

    bo_port #(.ADDR_W(ADDR_W)) u_lport (
        .clk(clk), .rst(rst), .acc(l_acc), .addr(lp_addr),
        .own_i(own_l), .chg_i(chg), .bank_rd(l_rd),
        .rdata_o(lp_rdata), .race_o(lp_clash)
    );

    bo_port #(.ADDR_W(ADDR_W)) u_rport (
        .clk(clk), .rst(rst), .acc(r_acc), .addr(rp_addr),
        .own_i(own_r), .chg_i(chg), .bank_rd(r_rd),
        .rdata_o(rp_rdata), .race_o(rp_clash)
    );

    // A bank taken by the left port is never also served to the right port.
    assert_exclusive_owner_R2: assert property (@(posedge clk) disable iff (rst)
        (own_l & own_r) == '0)
        else $error("bank owned by both ports");
endmodule

// File: tb/bo_dpram_tb.sv
module bo_dpram_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;

    typedef struct packed {
        logic [3:0]    sel;
        logic          lce;
        logic [1:0]    lbe;
        logic [AW-1:0] laddr;
        logic [15:0]   lwd;
        logic          rce;
        logic [1:0]    rbe;
        logic [AW-1:0] raddr;
        logic [15:0]   rwd;
        logic          lchk;
        logic [15:0]   lexp;
        logic          lrace;
        logic          rchk;
        logic [15:0]   rexp;
        logic          rrace;
    } vec_t;

    // sel | L ce be addr wd | R ce be addr wd | L chk exp race | R chk exp race
    localparam vec_t VEC [14] = '{
        '{4'b0011, 1'b1, 2'b11, 10'h005, 16'h1234, 1'b1, 2'b11, 10'h205, 16'hABCD, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0},
        '{4'b0011, 1'b1, 2'b00, 10'h005, 16'h0000, 1'b1, 2'b00, 10'h205, 16'h0000, 1'b1, 16'h1234, 1'b0, 1'b1, 16'hABCD, 1'b0},
        '{4'b0011, 1'b1, 2'b11, 10'h205, 16'hFFFF, 1'b1, 2'b00, 10'h205, 16'h0000, 1'b1, 16'hDEAD, 1'b0, 1'b1, 16'hABCD, 1'b0},
        '{4'b0011, 1'b0, 2'b00, 10'h000, 16'h0000, 1'b1, 2'b00, 10'h205, 16'h0000, 1'b1, 16'hDEAD, 1'b0, 1'b1, 16'hABCD, 1'b0},
        '{4'b0011, 1'b1, 2'b10, 10'h005, 16'h55AA, 1'b1, 2'b11, 10'h300, 16'h00EE, 1'b1, 16'h1234, 1'b0, 1'b0, 16'h0000, 1'b0},
        '{4'b0011, 1'b1, 2'b00, 10'h005, 16'h0000, 1'b1, 2'b00, 10'h005, 16'h0000, 1'b1, 16'h5534, 1'b0, 1'b1, 16'hDEAD, 1'b0},
        '{4'b1011, 1'b1, 2'b11, 10'h300, 16'h7777, 1'b1, 2'b00, 10'h205, 16'h0000, 1'b1, 16'hDEAD, 1'b1, 1'b1, 16'hABCD, 1'b0},
        '{4'b1011, 1'b1, 2'b00, 10'h300, 16'h0000, 1'b0, 2'b00, 10'h000, 16'h0000, 1'b1, 16'h00EE, 1'b0, 1'b1, 16'hABCD, 1'b0},
        '{4'b1111, 1'b1, 2'b00, 10'h005, 16'h0000, 1'b1, 2'b00, 10'h205, 16'h0000, 1'b1, 16'h5534, 1'b0, 1'b1, 16'hDEAD, 1'b1},
        '{4'b1111, 1'b1, 2'b00, 10'h205, 16'h0000, 1'b1, 2'b11, 10'h005, 16'h9999, 1'b1, 16'hABCD, 1'b0, 1'b1, 16'hDEAD, 1'b0},
        '{4'b0000, 1'b0, 2'b00, 10'h000, 16'h0000, 1'b0, 2'b00, 10'h000, 16'h0000, 1'b1, 16'hABCD, 1'b0, 1'b1, 16'hDEAD, 1'b0},
        '{4'b0000, 1'b1, 2'b00, 10'h300, 16'h0000, 1'b1, 2'b00, 10'h005, 16'h0000, 1'b1, 16'hDEAD, 1'b0, 1'b1, 16'h5534, 1'b0},
        '{4'b0000, 1'b0, 2'b00, 10'h000, 16'h0000, 1'b1, 2'b11, 10'h3FF, 16'h1357, 1'b1, 16'hDEAD, 1'b0, 1'b0, 16'h0000, 1'b0},
        '{4'b0000, 1'b0, 2'b00, 10'h000, 16'h0000, 1'b1, 2'b00, 10'h3FF, 16'h0000, 1'b1, 16'hDEAD, 1'b0, 1'b1, 16'h1357, 1'b0}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic [3:0] own_sel = 4'b0011;
    logic lp_ce = 0, rp_ce = 0;
    logic [1:0] lp_be = 0, rp_be = 0;
    logic [AW-1:0] lp_addr = 0, rp_addr = 0;
    logic [15:0] lp_wdata = 0, rp_wdata = 0;
    logic [15:0] lp_rdata, rp_rdata;
    logic lp_clash, rp_clash;
    int total = 0, bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bo_dpram #(.BANK_AW(8)) u_dut (
        .clk(clk), .rst(rst), .own_sel(own_sel),
        .lp_ce(lp_ce), .lp_be(lp_be), .lp_addr(lp_addr), .lp_wdata(lp_wdata),
        .lp_rdata(lp_rdata), .lp_clash(lp_clash),
        .rp_ce(rp_ce), .rp_be(rp_be), .rp_addr(rp_addr), .rp_wdata(rp_wdata),
        .rp_rdata(rp_rdata), .rp_clash(rp_clash)
    );

    task automatic check(string what, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        #1;
    endtask

    initial begin
        cycle();
        cycle();
        check("R11 reset lp_rdata", lp_rdata, 16'h0);
        check("R11 reset rp_rdata", rp_rdata, 16'h0);
        check("R11 reset lp_clash", {15'b0, lp_clash}, 16'h0);
        check("R11 reset rp_clash", {15'b0, rp_clash}, 16'h0);
        rst = 1'b0;

        // Table walk: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10
        for (int i = 0; i < 14; i++) begin
            own_sel = VEC[i].sel;
            lp_ce = VEC[i].lce; lp_be = VEC[i].lbe; lp_addr = VEC[i].laddr; lp_wdata = VEC[i].lwd;
            rp_ce = VEC[i].rce; rp_be = VEC[i].rbe; rp_addr = VEC[i].raddr; rp_wdata = VEC[i].rwd;
            cycle();
            if (VEC[i].lchk) begin
                check($sformatf("R4/R6/R10 vec %0d lp_rdata", i), lp_rdata, VEC[i].lexp);
                check($sformatf("R10 vec %0d lp_clash", i), {15'b0, lp_clash}, {15'b0, VEC[i].lrace});
            end
            if (VEC[i].rchk) begin
                check($sformatf("R4/R6/R9 vec %0d rp_rdata", i), rp_rdata, VEC[i].rexp);
                check($sformatf("R10 vec %0d rp_clash", i), {15'b0, rp_clash}, {15'b0, VEC[i].rrace});
            end
        end

        // R4 read-first on a lower-lane write (bank 0 is right-owned now), then R3 merge.
        lp_ce = 0;
        rp_ce = 1; rp_be = 2'b01; rp_addr = 10'h005; rp_wdata = 16'h1111;
        cycle();
        check("R4 read-before-write rp_rdata", rp_rdata, 16'h5534);
        rp_be = 2'b00;
        cycle();
        check("R3 lower lane only rp_rdata", rp_rdata, 16'h5511);

        // R10 flag lasts one cycle only.
        rp_ce = 0;
        cycle();
        check("R10 clash cleared rp_clash", {15'b0, rp_clash}, 16'h0);

        // R11 mid-run reset, memory kept.
        rst = 1'b1;
        cycle();
        check("R11 mid reset rp_rdata", rp_rdata, 16'h0);
        rst = 1'b0;
        rp_ce = 1; rp_addr = 10'h3FF;
        cycle();
        check("R11 memory kept across reset", rp_rdata, 16'h1357);
        rp_ce = 0;

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule